// File: doc/BRIEF.md
# Dialer Key Acceptance Filter

This block sits between a keypad decoder and the dialing engines of a telephone. For each key event it decides whether the key is accepted, and it forwards each accepted key as a one-cycle strobe. It applies three filters. Keys are refused while the handset is on-hook. A press of several keys at once is refused. While hold is engaged, every key except the hold key is refused.

It also bars long-distance calls. The first digit key after reset is compared against a lock setting. If that digit is barred, the block goes silent until the next reset.

Each accepted key starts a key-acknowledge square wave on the tone output. The block keeps the hold state itself and toggles a speech-mute output. Reset corresponds to the handset going off-hook.

Top module: `dial_key_gate`

## Requirements
- R1: When a key strobe (`keyValid` high for one cycle) is accepted, `outValid` is high for exactly one cycle on the next clock, and `outCode` equals the strobed `keyCode`. Codes 0 to 9 are digits, 12 is redial, 13 is mute and 14 is hold.
- R2: While `onHook` is high, no key is accepted.
- R3: A strobe with `multiKey` high is refused. It starts no tone and does not count as the first digit.
- R4: With `lockSel` = 0, no digit is barred.
- R5: With `lockSel` = 1, a first digit of 0 is refused. Every later key is then refused until reset. A first digit of 9 is accepted.
- R6: With `lockSel` = 2 or 3, a first digit of 0 or 9 is refused, and every later key is then refused until reset.
- R7: Only the first accepted digit after reset is examined. A non-digit key before it is accepted and leaves the check armed. Once a first digit has been accepted, later 0 and 9 digits pass.
- R8: An accepted hold key toggles `holdOn`. While `holdOn` is high, every key other than hold is refused.
- R9: An accepted mute key toggles `muteOn`. Nothing else changes it.
- R10: An accepted key drives `toneOut` high on the next clock. The wave alternates every `TONE_HALF_CYC` cycles for `TONE_HALFS` half periods, then rests low. A new accepted key restarts the wave from its first half.
- R11: After reset, `outValid`, `holdOn`, `muteOn` and `toneOut` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset (off-hook event) |
| keyValid | input | 1 | One-cycle key strobe |
| keyCode | input | 4 | Code of the strobed key |
| multiKey | input | 1 | Several keys pressed together |
| onHook | input | 1 | High when the handset is on-hook |
| lockSel | input | 2 | Barring setting: 0 none, 1 zero, 2/3 zero and nine |
| outValid | output | 1 | Accepted key strobe |
| outCode | output | 4 | Accepted key code |
| holdOn | output | 1 | Hold state |
| muteOn | output | 1 | Speech mute state |
| toneOut | output | 1 | Key-acknowledge square wave |

## Verification
An accepted or refused strobe settles `outValid`, `outCode`, `holdOn` and `muteOn` at the rising edge that captures the strobe. The first cycle of the tone appears at that same edge. The bench drives each strobe on a falling edge and samples all of these results on the next falling edge, exactly one register stage later. The tone is then compared sample by sample on each later falling edge against a wave computed from the elapsed cycle count. That count runs through the full `TONE_HALFS` x `TONE_HALF_CYC` window and a few cycles beyond it.

// File: rtl/key_gate_pkg.sv
package key_gate_pkg;
  localparam int KEY_W = 4;
  typedef logic [KEY_W-1:0] keyCode_t;

  localparam keyCode_t KEY_LAST_DIGIT = 4'd9;
  localparam keyCode_t KEY_MUTE       = 4'd13;
  localparam keyCode_t KEY_HOLD       = 4'd14;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;
    logic toggleMute;
  } gateCmd_t;
endpackage

// File: rtl/key_gate_ctrl.sv
module key_gate_ctrl
  import key_gate_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     keyValid,
  input  keyCode_t keyCode,
  input  logic     multiKey,
  input  logic     onHook,
  input  logic [1:0] lockSel,
  output gateCmd_t cmd,
  output logic     holdOn
);
  logic firstPending;
  logic lockedOut;
  logic isDigit, barred, live, holdPass, firstBar, toggleHold;

  always_comb begin
    isDigit    = keyCode <= KEY_LAST_DIGIT;
    barred     = ((keyCode == '0) && (lockSel != 2'd0)) ||
                 ((keyCode == KEY_LAST_DIGIT) && lockSel[1]);
    live       = keyValid && !onHook && !lockedOut && !multiKey;
    holdPass   = !holdOn || (keyCode == KEY_HOLD);
    firstBar   = firstPending && isDigit && barred;
    cmd.accept = live && holdPass && !firstBar;
    cmd.toggleMute = cmd.accept && (keyCode == KEY_MUTE);
    toggleHold = cmd.accept && (keyCode == KEY_HOLD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      firstPending <= 1'b1;
      lockedOut    <= 1'b0;
      holdOn       <= 1'b0;
    end else begin
      if (live && holdPass && firstBar) lockedOut <= 1'b1;
      if (cmd.accept && isDigit) firstPending <= 1'b0;
      if (toggleHold) holdOn <= !holdOn;
    end
  end
endmodule

// File: rtl/key_gate_dp.sv
module key_gate_dp
  import key_gate_pkg::*;
#(
  parameter int TONE_HALF_CYC = 1667,
  parameter int TONE_HALFS    = 84
) (
  input  logic     clk,
  input  logic     rstN,
  input  gateCmd_t cmd,
  input  keyCode_t keyCode,
  output logic     outValid,
  output keyCode_t outCode,
  output logic     muteOn,
  output logic     toneOut
);
  localparam int HC_W = $clog2(TONE_HALF_CYC + 1);
  localparam int HL_W = $clog2(TONE_HALFS + 1);
  localparam logic [HC_W-1:0] HALF_LAST = HC_W'(TONE_HALF_CYC - 1);
  localparam logic [HL_W-1:0] HALFS_START = HL_W'(TONE_HALFS - 1);

  logic            toneActive;
  logic [HC_W-1:0] halfCnt;
  logic [HL_W-1:0] halvesLeft;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outCode  <= '0;
      muteOn   <= 1'b0;
    end else begin
      outValid <= cmd.accept;
      if (cmd.accept) outCode <= keyCode;
      if (cmd.toggleMute) muteOn <= !muteOn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toneActive <= 1'b0;
      toneOut    <= 1'b0;
      halfCnt    <= '0;
      halvesLeft <= '0;
    end else if (cmd.accept) begin
      toneActive <= 1'b1;
      toneOut    <= 1'b1;
      halfCnt    <= '0;
      halvesLeft <= HALFS_START;
    end else if (toneActive) begin
      if (halfCnt == HALF_LAST) begin
        halfCnt <= '0;
        if (halvesLeft == '0) begin
          toneActive <= 1'b0;
          toneOut    <= 1'b0;
        end else begin
          toneOut    <= !toneOut;
          halvesLeft <= halvesLeft - 1'b1;
        end
      end else begin
        halfCnt <= halfCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dial_key_gate.sv
module dial_key_gate
  import key_gate_pkg::*;
#(
  parameter int TONE_HALF_CYC = 1667,
  parameter int TONE_HALFS    = 84
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       keyValid,
  input  logic [3:0] keyCode,
  input  logic       multiKey,
  input  logic       onHook,
  input  logic [1:0] lockSel,
  output logic       outValid,
  output logic [3:0] outCode,
  output logic       holdOn,
  output logic       muteOn,
  output logic       toneOut
);
  gateCmd_t cmd;

  key_gate_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .keyValid(keyValid), .keyCode(keyCode),
    .multiKey(multiKey), .onHook(onHook), .lockSel(lockSel),
    .cmd(cmd), .holdOn(holdOn)
  );

  key_gate_dp #(.TONE_HALF_CYC(TONE_HALF_CYC), .TONE_HALFS(TONE_HALFS)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .keyCode(keyCode),
    .outValid(outValid), .outCode(outCode), .muteOn(muteOn), .toneOut(toneOut)
  );
endmodule

// File: rtl/key_gate_chk.sv
module key_gate_chk
  import key_gate_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       keyValid,
  input logic [3:0] keyCode,
  input logic       multiKey,
  input logic       onHook,
  input logic       outValid,
  input logic [3:0] outCode,
  input logic       holdOn,
  input logic       muteOn,
  input logic       toneOut
);
  // R1
  forward_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ($past(keyValid) && outCode == $past(keyCode)));
  // R2
  onhook_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (keyValid && onHook) |=> !outValid);
  // R3
  multi_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (keyValid && multiKey) |=> !outValid);
  // R8
  hold_filter_chk: assert property (@(posedge clk) disable iff (!rstN)
    (holdOn && keyValid && keyCode != KEY_HOLD) |=> !outValid);
  // R9
  mute_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(muteOn) |-> $past(keyValid && keyCode == KEY_MUTE));
  // R10
  tone_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> toneOut);
endmodule

bind dial_key_gate key_gate_chk u_chk (.*);

// File: tb/dial_key_gate_tb.sv
module dial_key_gate_tb;
  localparam int HALF = 4;
  localparam int HALFS = 84;
  localparam int TOTAL = HALF * HALFS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic keyValid = 1'b0;
  logic [3:0] keyCode = '0;
  logic multiKey = 1'b0;
  logic onHook = 1'b0;
  logic [1:0] lockSel = '0;
  logic outValid, holdOn, muteOn, toneOut;
  logic [3:0] outCode;

  int nRun = 0, nFail = 0;
  bit done = 0;
  bit mFirst, mLocked, mHold, mMute;

  always #2.5 clk = !clk;

  dial_key_gate #(.TONE_HALF_CYC(HALF), .TONE_HALFS(HALFS)) u_dut (
    .clk(clk), .rstN(rstN), .keyValid(keyValid), .keyCode(keyCode),
    .multiKey(multiKey), .onHook(onHook), .lockSel(lockSel),
    .outValid(outValid), .outCode(outCode), .holdOn(holdOn),
    .muteOn(muteOn), .toneOut(toneOut)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit isBarred(logic [1:0] lk, logic [3:0] c);
    return (c == 4'd0 && lk != 2'd0) || (c == 4'd9 && lk[1]);
  endfunction

  // model step: returns whether the key is accepted
  function automatic bit modelKey(logic [3:0] c, bit multi);
    if (onHook || mLocked || multi) return 0;
    if (mHold && c != 4'd14) return 0;
    if (mFirst && c <= 4'd9) begin
      if (isBarred(lockSel, c)) begin
        mLocked = 1;
        return 0;
      end
      mFirst = 0;
    end
    if (c == 4'd14) mHold = !mHold;
    if (c == 4'd13) mMute = !mMute;
    return 1;
  endfunction

  task automatic doReset(logic [1:0] lk);
    @(negedge clk);
    rstN = 1'b0;
    lockSel = lk;
    mFirst = 1; mLocked = 0; mHold = 0; mMute = 0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic sendKey(logic [3:0] c, bit multi, string req);
    bit acc;
    @(negedge clk);
    keyValid = 1'b1; keyCode = c; multiKey = multi;
    acc = modelKey(c, multi);
    @(negedge clk);
    keyValid = 1'b0; multiKey = 1'b0;
    chk(outValid == acc, req, outValid, acc);
    if (acc) chk(outCode == c, req, outCode, c);
    chk(holdOn == mHold, req, holdOn, mHold);
    chk(muteOn == mMute, req, muteOn, mMute);
  endtask

  // called at the first falling edge after an accepting strobe
  task automatic checkTone(string req);
    int bad = 0, firstBad = -1;
    for (int i = 0; i < TOTAL + 4; i++) begin
      bit exp = (i < TOTAL) ? (((i / HALF) % 2) == 0) : 1'b0;
      if (toneOut !== exp) begin
        bad++;
        if (firstBad < 0) firstBad = i;
      end
      @(negedge clk);
    end
    chk(bad == 0, req, firstBad, -1);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    int idle;
    doReset(2'd0);
    @(negedge clk);
    // R11 reset state
    chk(!outValid && !holdOn && !muteOn && !toneOut, "R11",
        {outValid, holdOn, muteOn, toneOut}, 0);

    // R4 no barring
    sendKey(4'd0, 0, "R4");
    // R5 zero barred, nine passes, later zero passes (R7)
    doReset(2'd1);
    sendKey(4'd9, 0, "R5");
    sendKey(4'd0, 0, "R7");
    doReset(2'd1);
    sendKey(4'd12, 0, "R7");
    sendKey(4'd0, 0, "R5");
    sendKey(4'd5, 0, "R5");
    sendKey(4'd14, 0, "R5");
    // R6 nine barred
    doReset(2'd2);
    sendKey(4'd9, 0, "R6");
    sendKey(4'd3, 0, "R6");
    doReset(2'd3);
    sendKey(4'd0, 0, "R6");
    sendKey(4'd9, 0, "R6");
    // R3 multi-key not counted as first
    doReset(2'd1);
    sendKey(4'd4, 1, "R3");
    sendKey(4'd0, 0, "R3");
    // R8 hold
    doReset(2'd0);
    sendKey(4'd14, 0, "R8");
    sendKey(4'd5, 0, "R8");
    sendKey(4'd13, 0, "R8");
    sendKey(4'd14, 0, "R8");
    sendKey(4'd5, 0, "R8");
    // R9 mute
    sendKey(4'd13, 0, "R9");
    sendKey(4'd7, 0, "R9");
    sendKey(4'd13, 0, "R9");
    // R2 on-hook
    onHook = 1'b1;
    sendKey(4'd5, 0, "R2");
    sendKey(4'd13, 0, "R2");
    onHook = 1'b0;

    // R3 no tone on multi-key
    repeat (TOTAL + 10) @(negedge clk);
    sendKey(4'd6, 1, "R3");
    idle = 0;
    for (int i = 0; i < 3 * HALF; i++) begin
      if (toneOut) idle++;
      @(negedge clk);
    end
    chk(idle == 0, "R3", idle, 0);
    // R10 full wave
    sendKey(4'd2, 0, "R10");
    checkTone("R10");
    // R10 restart mid-wave
    sendKey(4'd3, 0, "R10");
    repeat (2 * HALF + 1) @(negedge clk);
    sendKey(4'd4, 0, "R10");
    checkTone("R10");

    // random phase, fixed seed
    void'($urandom(32'd1234));
    for (int n = 0; n < 600; n++) begin
      logic [3:0] c;
      bit m;
      if ($urandom_range(0, 49) == 0) doReset(2'($urandom_range(0, 3)));
      onHook = ($urandom_range(0, 9) == 0);
      c = 4'($urandom_range(0, 15));
      m = ($urandom_range(0, 7) == 0);
      sendKey(c, m, "R1");
      onHook = 1'b0;
      if ($urandom_range(0, 3) == 0) @(negedge clk);
    end
    finishRun();
  end
endmodule